// File: doc/BRIEF.md
# Serial Bus Clock-Low Timeout Monitor

This block sits between the pad synchronisers of a two-wire serial slave and its protocol decoder. It cleans both bus lines with a stability filter, follows the transaction framing on the cleaned lines, and measures each interval in which the clock line stays low while a transaction is open. If one low interval lasts as long as the selected limit, the block issues a one-cycle abort. The decoder uses that pulse to let go of the data line and wait for a fresh start. The block also sets a sticky timeout flag, which the next start clears.

The filter width depends on the bus speed. The wider setting serves buses below 100 kHz, where glitches of up to 100 ns must be rejected. The narrower setting serves buses up to 400 kHz, where the limit is 50 ns. The timeout limit comes from one of two settings. The narrow setting targets the 25–35 ms range that the system-management bus requires, with a nominal trip at 30 ms. The wide setting targets a 10–60 ms tolerance. Both limits are counted in system-clock ticks. The block has no power-state input, so it keeps working while the sensor core is shut down.

Top module: `scl_low_watchdog`

## Requirements
- R1: After reset both filtered outputs are 1, and the abort and timeout outputs are 0.
- R2: A filtered line takes a new input value only after that value has been present for N consecutive clock cycles. N is FLT_FAST_TICKS when `fast_i`=1 and FLT_SLOW_TICKS when `fast_i`=0. An input pulse shorter than N cycles never reaches the output.
- R3: A change that passes the filter shows at the filtered output exactly N cycles after it appears at the input.
- R4: A transaction opens when filtered SDA falls while filtered SCL is high (start). It closes when filtered SDA rises while filtered SCL is high (stop). Outside a transaction a low SCL of any length produces no abort.
- R5: The low-time count restarts whenever filtered SCL is high. Two low intervals, each shorter than the limit, never combine into an abort.
- R6: The abort pulse is asserted exactly LIM cycles after filtered SCL falls. LIM is TMO_SMBUS_TICKS when `win_sel_i`=1 and TMO_WIDE_TICKS when `win_sel_i`=0.
- R7: Each abort lasts exactly one cycle and closes the transaction. Further low intervals produce no abort until a new start.
- R8: `timeout_o` rises together with the abort and stays high through later bus activity until the next start clears it.
- R9: A filtered SCL low interval of LIM-1 cycles produces no abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Synchronised SCL |
| sda_i | input | 1 | Synchronised SDA |
| fast_i | input | 1 | 1: bus above 100 kHz (short filter); 0: slow bus (long filter) |
| win_sel_i | input | 1 | 1: 25–35 ms timeout; 0: wide 10–60 ms timeout |
| scl_o | output | 1 | Filtered SCL |
| sda_o | output | 1 | Filtered SDA |
| abort_o | output | 1 | One-cycle abort pulse |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The bench changes an input at a falling clock edge and counts falling edges from that point. A filtered output is due at the N-th falling edge after the input change. The abort is due LIM falling edges after filtered SCL is first seen low, so at falling edge N+LIM of the low pulse. The timeout flag is read at that same edge. Every check samples at exactly those edges, so a design that is off by one cycle either way fails. The bench sweeps glitch widths from 1 to N+1 on both lines at both filter settings. In each transaction state it drives clock-low intervals of LIM-1 and LIM cycles at both window settings.

// File: rtl/scl_wd_pkg.sv
package scl_wd_pkg;
  typedef enum logic {WIN_WIDE = 1'b0, WIN_SMBUS = 1'b1} win_e;

  typedef struct packed {
    logic start;
    logic stop;
  } bus_evt_t;
endpackage

// File: rtl/line_deglitch.sv
module line_deglitch #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] lim_i,
  input  logic          d_i,
  output logic          q_o
);
  logic [CW-1:0] cnt_q;
  logic          q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= 1'b1;
      cnt_q <= '0;
    end else if (d_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q + CW'(1) >= lim_i) begin
      // new level has now been seen lim_i times in a row
      q_q   <= d_i;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/bus_evt_det.sv
module bus_evt_det
  import scl_wd_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
    end
  end

  assign evt_o.start = scl_i & scl_p & sda_p & ~sda_i;
  assign evt_o.stop  = scl_i & scl_p & ~sda_p & sda_i;
endmodule

// File: rtl/low_timer.sv
module low_timer
  import scl_wd_pkg::*;
#(
  parameter int TW = 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_evt_t      evt_i,
  input  logic          scl_i,
  input  logic [TW-1:0] lim_i,
  output logic          abort_o,
  output logic          timeout_o
);
  logic          busy_q, abort_q, tmo_q;
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      abort_q <= 1'b0;
      tmo_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      abort_q <= 1'b0;
      if (evt_i.start) begin
        busy_q <= 1'b1;
        tmo_q  <= 1'b0;
        cnt_q  <= '0;
      end else if (evt_i.stop) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q && !scl_i) begin
        if (cnt_q == lim_i - TW'(1)) begin
          abort_q <= 1'b1;
          tmo_q   <= 1'b1;
          busy_q  <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + TW'(1);
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign abort_o   = abort_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/scl_low_watchdog.sv
module scl_low_watchdog
  import scl_wd_pkg::*;
#(
  parameter int FLT_SLOW_TICKS  = 13,
  parameter int FLT_FAST_TICKS  = 7,
  parameter int TMO_SMBUS_TICKS = 3_750_000,
  parameter int TMO_WIDE_TICKS  = 4_375_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic fast_i,
  input  logic win_sel_i,
  output logic scl_o,
  output logic sda_o,
  output logic abort_o,
  output logic timeout_o
);
  localparam int FLT_MAX = (FLT_SLOW_TICKS > FLT_FAST_TICKS) ? FLT_SLOW_TICKS : FLT_FAST_TICKS;
  localparam int TMO_MAX = (TMO_SMBUS_TICKS > TMO_WIDE_TICKS) ? TMO_SMBUS_TICKS : TMO_WIDE_TICKS;
  localparam int FLT_W   = $clog2(FLT_MAX + 1);
  localparam int TMO_W   = $clog2(TMO_MAX + 1);
  localparam int NLINES  = 2;

  logic [FLT_W-1:0]  flt_lim;
  logic [TMO_W-1:0]  tmo_lim;
  logic [NLINES-1:0] raw, clean;
  bus_evt_t          evt;

  assign flt_lim = fast_i ? FLT_W'(FLT_FAST_TICKS) : FLT_W'(FLT_SLOW_TICKS);
  assign tmo_lim = (win_e'(win_sel_i) == WIN_SMBUS) ? TMO_W'(TMO_SMBUS_TICKS)
                                                    : TMO_W'(TMO_WIDE_TICKS);
  assign raw     = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_flt
    line_deglitch #(.CW(FLT_W)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lim_i  (flt_lim),
      .d_i    (raw[g]),
      .q_o    (clean[g])
    );
  end

  bus_evt_det u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (clean[0]),
    .sda_i  (clean[1]),
    .evt_o  (evt)
  );

  low_timer #(.TW(TMO_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt),
    .scl_i     (clean[0]),
    .lim_i     (tmo_lim),
    .abort_o   (abort_o),
    .timeout_o (timeout_o)
  );

  assign scl_o = clean[0];
  assign sda_o = clean[1];
endmodule

// File: rtl/scl_low_watchdog_chk.sv
module scl_low_watchdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic scl_o,
  input logic sda_o,
  input logic abort_o,
  input logic timeout_o
);
  logic armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  // R2
  scl_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$stable(scl_o) |-> scl_o == $past(scl_i));

  // R2
  sda_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    !$stable(sda_o) |-> sda_o == $past(sda_i));

  // R7
  abort_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    abort_o |=> !abort_o);

  // R6
  abort_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    abort_o |-> !$past(scl_o));

  // R8
  tmo_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $rose(timeout_o) |-> abort_o);

  // R8
  tmo_with_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    abort_o |-> timeout_o);
endmodule

bind scl_low_watchdog scl_low_watchdog_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .sda_i     (sda_i),
  .scl_o     (scl_o),
  .sda_o     (sda_o),
  .abort_o   (abort_o),
  .timeout_o (timeout_o)
);

// File: tb/scl_low_watchdog_tb.sv
module scl_low_watchdog_tb;
  localparam int SLOW = 6;
  localparam int FAST = 3;
  localparam int LSMB = 40;
  localparam int LWID = 70;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, fast_i = 1'b0, win_sel_i = 1'b1;
  logic scl_o, sda_o, abort_o, timeout_o;
  int   errs = 0, checks = 0;
  bit   done = 1'b0;

  always #4 clk_i = ~clk_i;

  scl_low_watchdog #(
    .FLT_SLOW_TICKS (SLOW),
    .FLT_FAST_TICKS (FAST),
    .TMO_SMBUS_TICKS(LSMB),
    .TMO_WIDE_TICKS (LWID)
  ) u_dut (
    .clk_i, .rst_ni, .scl_i, .sda_i, .fast_i, .win_sel_i,
    .scl_o, .sda_o, .abort_o, .timeout_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_start();
    scl_i = 1'b1; sda_i = 1'b1; cyc(10);
    sda_i = 1'b0; cyc(10);
  endtask

  task automatic do_stop();
    scl_i = 1'b0; cyc(10);
    sda_i = 1'b0; cyc(10);
    scl_i = 1'b1; cyc(10);
    sda_i = 1'b1; cyc(10);
  endtask

  // drive one line low for w cycles; report first negedge its output is low
  task automatic glitch(input int sel, input int w, input int n, output int first, output bit back);
    first = -1;
    if (sel == 0) scl_i = 1'b0; else sda_i = 1'b0;
    for (int c = 1; c <= w + n + 5; c++) begin
      @(negedge clk_i);
      if (first < 0 && ((sel == 0) ? !scl_o : !sda_o)) first = c;
      if (c == w) begin
        if (sel == 0) scl_i = 1'b1; else sda_i = 1'b1;
      end
    end
    back = (sel == 0) ? scl_o : sda_o;
  endtask

  // SCL low for d cycles; report fall of scl_o, first abort, abort count
  task automatic low_pulse(input int d, output int fall_at, output int ab_at, output int ab_cnt);
    fall_at = -1; ab_at = -1; ab_cnt = 0;
    scl_i = 1'b0;
    for (int c = 1; c <= d + LWID + 20; c++) begin
      @(negedge clk_i);
      if (fall_at < 0 && !scl_o) fall_at = c;
      if (abort_o) begin
        ab_cnt++;
        if (ab_at < 0) ab_at = c;
      end
      if (c == d) scl_i = 1'b1;
    end
  endtask

  initial begin
    int first, fall_at, ab_at, ab_cnt, n, lim;
    bit back;
    cyc(3);
    // R1
    chk(scl_o && sda_o && !abort_o && !timeout_o, "R1 reset",
        {scl_o, sda_o, abort_o, timeout_o}, 4'b1100);
    rst_ni = 1'b1;
    cyc(3);
    chk(scl_o && sda_o && !abort_o && !timeout_o, "R1 after release",
        {scl_o, sda_o, abort_o, timeout_o}, 4'b1100);

    // R4: long low with no transaction open
    low_pulse(LWID + 20, fall_at, ab_at, ab_cnt);
    chk(ab_cnt == 0, "R4 idle low", ab_cnt, 0);
    cyc(10);

    // R2/R3 sweep on both lines, both filter settings
    for (int f = 0; f < 2; f++) begin
      fast_i = f[0];
      n = f ? FAST : SLOW;
      cyc(10);
      for (int sel = 0; sel < 2; sel++) begin
        if (sel == 1) begin scl_i = 1'b0; cyc(10); end
        for (int w = 1; w <= n + 1; w++) begin
          glitch(sel, w, n, first, back);
          if (w < n) chk(first == -1, "R2 glitch rejected", first, -1);
          else       chk(first == n, "R3 filter latency", first, n);
          chk(back == 1'b1, "R2 line restored", back, 1);
          cyc(n + 2);
        end
        if (sel == 1) begin scl_i = 1'b1; cyc(10); end
      end
    end
    chk(!timeout_o, "R4 no timeout while idle", timeout_o, 0);

    // timeout windows
    fast_i = 1'b1;
    for (int win = 0; win < 2; win++) begin
      win_sel_i = win[0];
      lim = win ? LSMB : LWID;
      do_start();
      low_pulse(lim - 1, fall_at, ab_at, ab_cnt);
      chk(ab_cnt == 0, "R9 limit minus one", ab_cnt, 0);
      chk(fall_at == FAST, "R3 scl_o fall", fall_at, FAST);
      cyc(10);
      // R5: second sub-limit low must not add to the first
      low_pulse(lim - 1, fall_at, ab_at, ab_cnt);
      chk(ab_cnt == 0, "R5 count restarts on high", ab_cnt, 0);
      cyc(10);
      low_pulse(lim, fall_at, ab_at, ab_cnt);
      chk(ab_at == FAST + lim, "R6 abort timing", ab_at, FAST + lim);
      chk(ab_cnt == 1, "R7 single pulse", ab_cnt, 1);
      chk(timeout_o, "R8 timeout set", timeout_o, 1);
      cyc(10);
      low_pulse(lim + 30, fall_at, ab_at, ab_cnt);
      chk(ab_cnt == 0, "R7 no abort until new start", ab_cnt, 0);
      chk(timeout_o, "R8 timeout sticky", timeout_o, 1);
      do_start();
      chk(!timeout_o, "R8 cleared by start", timeout_o, 0);
      do_stop();
      low_pulse(lim + 10, fall_at, ab_at, ab_cnt);
      chk(ab_cnt == 0, "R4 no abort after stop", ab_cnt, 0);
      cyc(10);
    end

    // R6 slow filter with narrow window
    fast_i = 1'b0; win_sel_i = 1'b1; cyc(10);
    do_start();
    low_pulse(LSMB, fall_at, ab_at, ab_cnt);
    chk(ab_at == SLOW + LSMB, "R6 abort timing slow filter", ab_at, SLOW + LSMB);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule